// File: doc/BRIEF.md
# Reloadable Constant-Coefficient Multiplier

This block multiplies a 16-bit unsigned sample by a coefficient that is held inside the block. It contains no general multiplier. The sample is cut into four 4-bit nibbles. Each nibble selects one word from its own 16-word product table, and that table holds every multiple 0·K through 15·K of the coefficient K. The four words are weighted by 1, 16, 256 and 4096 and summed in a two-stage pipelined adder tree. A full 32-bit product appears a fixed three cycles after the sample is accepted.

The coefficient can be replaced while the block runs. A change request captures the new value and clears an accumulator. For sixteen cycles the loader then pushes the running sum into every table and adds the coefficient once per step. Each table is a push-only shift store: the newest word enters at the top entry and older words move one entry down. After sixteen pushes, entry n holds n·K.

The loader is a two-state machine. `LD_IDLE` waits for a request. The transition START (IDLE to FILL) is taken on a change request. In `LD_FILL` the loader pushes one multiple per cycle and raises busy. The transition STEP (FILL to FILL) repeats for the first fifteen pushes. The transition DONE (FILL to IDLE) follows the sixteenth push.

Top module: `kmul_reload`

## Requirements
- R1: After reset, busy and out_valid are low and every table holds zero, so any accepted sample yields a product of 0 until the first reload completes.
- R2: For each accepted sample D, out_product equals D·K as an unsigned 32-bit value, where K is the coefficient whose reload last completed.
- R3: A sample is accepted when in_valid is high and busy is low in a cycle. out_valid is high exactly three cycles later, with one result per accepted sample, including on back-to-back cycles.
- R4: A change request while busy is low captures k_new. busy is high for exactly the 16 cycles that follow the request cycle and low otherwise.
- R5: in_valid while busy is high is ignored: no out_valid results from it.
- R6: A change request while busy is high is ignored: the reload in progress completes with its own coefficient.
- R7: Samples accepted in or before the request cycle complete with the previous coefficient.
- R8: After a reload, a sample whose only non-zero nibble is nibble j with value n (nibble 0 being bits 3:0) yields n·K·16^j, which shows entry n of table j equals n·K.
- R9: The extreme coefficients 0, 1 and 0xFFFF give exact products for samples 0, 1, 0x8000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present on in_data |
| in_data | input | 16 | Unsigned sample |
| k_new | input | 16 | Coefficient taken by a change request |
| k_change | input | 1 | Request to reload the tables with k_new |
| busy | output | 1 | Reload in progress; samples and requests are ignored |
| out_valid | output | 1 | out_product holds a result |
| out_product | output | 32 | Unsigned product |

## Verification
Single-nibble samples with one nibble set at a time walk every entry of every table, so a wrong table entry shows up separately from a wrong nibble weight. All-ones samples with an all-ones coefficient exercise the widest carries through both adder stages. Samples placed in the request cycle and during busy separate the old and new coefficient, and show whether ignored inputs leak into results. Long random runs mix idle gaps, back-to-back samples and occasional reloads, which tests the latency and the count of results.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1
    } ld_state_t;

endpackage

// File: rtl/kmul_table.sv
// Push-only product table: newest word enters the top entry, others shift down.
module kmul_table #(
    parameter int DEPTH = 16,
    parameter int W     = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             push_word,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_word
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                mem[i] <= mem[i+1];
            end
            mem[DEPTH-1] <= push_word;
        end
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/kmul_loader.sv
// Reload sequencer: clears the accumulator, then pushes 0*K .. (DEPTH-1)*K.
module kmul_loader
    import kmul_pkg::*;
#(
    parameter int K_W   = 16,
    parameter int TW    = 20,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chg_req,
    input  logic [K_W-1:0] k_in,
    output logic          busy,
    output logic          push,
    output logic [TW-1:0] push_word
);

    localparam int CW = $clog2(DEPTH);

    ld_state_t      st, st_nx;
    logic [K_W-1:0] k_hold;
    logic [TW-1:0]  acc;
    logic [CW-1:0]  step;
    logic           last_step;

    assign last_step = (step == CW'(DEPTH - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= LD_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions: START, STEP, DONE
    always_comb begin
        st_nx = st;
        unique case (st)
            LD_IDLE: if (chg_req)   st_nx = LD_FILL;
            LD_FILL: if (last_step) st_nx = LD_IDLE;
            default:                st_nx = LD_IDLE;
        endcase
    end

    // constant register, accumulator and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_hold <= '0;
            acc    <= '0;
            step   <= '0;
        end else begin
            unique case (st)
                LD_IDLE: begin
                    if (chg_req) begin
                        k_hold <= k_in;
                        acc    <= '0;
                        step   <= '0;
                    end
                end
                LD_FILL: begin
                    acc  <= acc + {{(TW-K_W){1'b0}}, k_hold};
                    step <= step + 1'b1;
                end
                default: begin
                    acc  <= '0;
                    step <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        push = 1'b0;
        unique case (st)
            LD_IDLE: begin
                busy = 1'b0;
                push = 1'b0;
            end
            LD_FILL: begin
                busy = 1'b1;
                push = 1'b1;
            end
            default: begin
                busy = 1'b0;
                push = 1'b0;
            end
        endcase
    end

    assign push_word = acc;

endmodule

// File: rtl/kmul_sum_tree.sv
// Two-stage weighted adder: pairs of nibble products, then the final sum.
module kmul_sum_tree #(
    parameter int NN    = 4,
    parameter int NIB_W = 4,
    parameter int K_W   = 16,
    parameter int TW    = 20,
    parameter int PW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [NN*TW-1:0] parts,
    output logic             out_v,
    output logic [PW-1:0]    sum
);

    localparam int NP = NN / 2;
    localparam int SW = K_W + 2 * NIB_W;

    logic [SW-1:0] pair_d [NP];
    logic [SW-1:0] pair_q [NP];
    logic          v2;
    logic [PW-1:0] total_d;

    for (genvar j = 0; j < NP; j++) begin : g_pair
        assign pair_d[j] = SW'(parts[(2*j)*TW +: TW])
                         + (SW'(parts[(2*j+1)*TW +: TW]) << NIB_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2 <= 1'b0;
            for (int j = 0; j < NP; j++) begin
                pair_q[j] <= '0;
            end
        end else begin
            v2 <= in_v;
            if (in_v) begin
                for (int j = 0; j < NP; j++) begin
                    pair_q[j] <= pair_d[j];
                end
            end
        end
    end

    always_comb begin
        total_d = '0;
        for (int j = 0; j < NP; j++) begin
            total_d = total_d + (PW'(pair_q[j]) << (2 * NIB_W * j));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            sum   <= '0;
        end else begin
            out_v <= v2;
            if (v2) begin
                sum <= total_d;
            end
        end
    end

endmodule

// File: rtl/kmul_reload.sv
module kmul_reload #(
    parameter int DATA_W = 16,
    parameter int K_W    = 16,
    parameter int NIB_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [K_W-1:0]        k_new,
    input  logic                  k_change,
    output logic                  busy,
    output logic                  out_valid,
    output logic [DATA_W+K_W-1:0] out_product
);

    localparam int NN  = DATA_W / NIB_W;
    localparam int ENT = 1 << NIB_W;
    localparam int TW  = K_W + NIB_W;
    localparam int PW  = DATA_W + K_W;

    logic             push;
    logic [TW-1:0]    push_word;
    logic             accept;
    logic [TW-1:0]    rd_word [NN];
    logic [NN*TW-1:0] part_q;
    logic             v1;

    kmul_loader #(.K_W(K_W), .TW(TW), .DEPTH(ENT)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_req   (k_change),
        .k_in      (k_new),
        .busy      (busy),
        .push      (push),
        .push_word (push_word)
    );

    assign accept = in_valid & ~busy;

    for (genvar g = 0; g < NN; g++) begin : g_tab
        kmul_table #(.DEPTH(ENT), .W(TW)) u_tab (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_word (push_word),
            .rd_idx    (in_data[g*NIB_W +: NIB_W]),
            .rd_word   (rd_word[g])
        );
    end

    // table register: first pipeline stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            part_q <= '0;
        end else begin
            v1 <= accept;
            if (accept) begin
                for (int g = 0; g < NN; g++) begin
                    part_q[g*TW +: TW] <= rd_word[g];
                end
            end
        end
    end

    kmul_sum_tree #(.NN(NN), .NIB_W(NIB_W), .K_W(K_W), .TW(TW), .PW(PW)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (v1),
        .parts (part_q),
        .out_v (out_valid),
        .sum   (out_product)
    );

endmodule

// File: rtl/kmul_reload_chk.sv
module kmul_reload_chk #(
    parameter int DATA_W = 16,
    parameter int K_W    = 16,
    parameter int NIB_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [DATA_W-1:0]     in_data,
    input logic [K_W-1:0]        k_new,
    input logic                  k_change,
    input logic                  busy,
    input logic                  out_valid,
    input logic [DATA_W+K_W-1:0] out_product
);

    localparam int ENT = 1 << NIB_W;

    logic [7:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && !busy, 3)); // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == 8'(ENT)); // R4

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (k_change && !busy) |=> busy); // R4

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(k_change)); // R4

    AST_BUSY_DROPS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> ##2 !out_valid); // R5

endmodule

bind kmul_reload kmul_reload_chk #(.DATA_W(DATA_W), .K_W(K_W), .NIB_W(NIB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .k_new       (k_new),
    .k_change    (k_change),
    .busy        (busy),
    .out_valid   (out_valid),
    .out_product (out_product)
);

// File: tb/sim_kmul_reload.sv
module sim_kmul_reload;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic [15:0] k_new;
    logic        k_change;
    logic        busy;
    logic        out_valid;
    logic [31:0] out_product;

    always #10 clk = ~clk;

    kmul_reload u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .k_new       (k_new),
        .k_change    (k_change),
        .busy        (busy),
        .out_valid   (out_valid),
        .out_product (out_product)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_tag = "R2";

    // requirement model
    bit [15:0] m_k    = 16'd0;
    bit [15:0] m_pend = 16'd0;
    int        m_cnt  = 0;
    bit        pv [1:3];
    bit [31:0] pp [1:3];

    function automatic bit [31:0] ref_mul(bit [15:0] d, bit [15:0] k);
        return {16'd0, d} * {16'd0, k};
    endfunction

    task automatic cyc(input bit v, input bit [15:0] d, input bit req, input bit [15:0] nk);
        bit acc;
        n_chk++;
        if (busy !== (m_cnt > 0)) begin
            n_bad++;
            $display("FAIL R4 busy actual=%0b expected=%0b", busy, (m_cnt > 0));
        end
        n_chk++;
        if (out_valid !== pv[3]) begin
            n_bad++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", cur_tag, out_valid, pv[3]);
        end else if (pv[3]) begin
            n_chk++;
            if (out_product !== pp[3]) begin
                n_bad++;
                $display("FAIL %s product actual=%h expected=%h", cur_tag, out_product, pp[3]);
            end
        end
        in_valid = v;
        in_data  = d;
        k_change = req;
        k_new    = nk;
        acc = v && (m_cnt == 0);
        pv[3] = pv[2]; pp[3] = pp[2];
        pv[2] = pv[1]; pp[2] = pp[1];
        pv[1] = acc;   pp[1] = ref_mul(d, m_k);
        if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) m_k = m_pend;
        end else if (req) begin
            m_cnt  = 16;
            m_pend = nk;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'd0, 1'b0, 16'd0);
    endtask

    task automatic reload(input bit [15:0] k);
        cyc(1'b0, 16'd0, 1'b1, k);
        idle(16);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        for (int i = 1; i <= 3; i++) begin pv[i] = 1'b0; pp[i] = 32'd0; end
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; k_new = '0; k_change = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (busy !== 1'b0 || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset busy/out_valid actual=%0b%0b expected=00", busy, out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero tables give zero products
        cur_tag = "R1";
        cyc(1'b1, 16'hFFFF, 1'b0, 16'd0);
        cyc(1'b1, 16'h1234, 1'b0, 16'd0);
        idle(3);

        // R7: samples in and before the request cycle use the old constant
        cur_tag = "R7";
        reload(16'd7);
        cyc(1'b1, 16'h0101, 1'b0, 16'd0);
        cyc(1'b1, 16'h0003, 1'b1, 16'd3);

        // R5: samples during busy are dropped; R6: second request is dropped
        cur_tag = "R5";
        for (int i = 0; i < 16; i++)
            cyc(1'b1, 16'($urandom), (i == 5), 16'd999);
        cur_tag = "R6";
        cyc(1'b1, 16'h0001, 1'b0, 16'd0);
        cyc(1'b1, 16'hABCD, 1'b0, 16'd0);
        idle(3);

        // R8: walk every entry of every table
        cur_tag = "R8";
        reload(16'h1234);
        for (int j = 0; j < 4; j++)
            for (int n = 0; n < 16; n++)
                cyc(1'b1, 16'(n << (4 * j)), 1'b0, 16'd0);
        idle(3);

        // R9: extreme coefficients
        cur_tag = "R9";
        reload(16'hFFFF);
        cyc(1'b1, 16'hFFFF, 1'b0, 16'd0);
        cyc(1'b1, 16'h0000, 1'b0, 16'd0);
        cyc(1'b1, 16'h0001, 1'b0, 16'd0);
        cyc(1'b1, 16'h8000, 1'b0, 16'd0);
        reload(16'd1);
        cyc(1'b1, 16'hFFFF, 1'b0, 16'd0);
        cyc(1'b1, 16'h8000, 1'b0, 16'd0);
        reload(16'd0);
        cyc(1'b1, 16'hFFFF, 1'b0, 16'd0);
        idle(3);

        // R3: back-to-back samples
        cur_tag = "R3";
        reload(16'h00F1);
        for (int i = 0; i < 24; i++) cyc(1'b1, 16'($urandom), 1'b0, 16'd0);
        idle(4);

        // R2: random mix with occasional reloads
        cur_tag = "R2";
        for (int i = 0; i < 3000; i++)
            cyc(($urandom_range(0, 9) < 7), 16'($urandom),
                ($urandom_range(0, 199) == 0), 16'($urandom));
        idle(20);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule